// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins controlled through a 32-bit register port. Each pin works in one of three ways:

- a general input, read back through an input-data register;
- a general output, driven from an output-data register;
- an interrupt source.

An interrupt pin is sampled through a two-flop synchronizer. It can sense a level or an edge. The active sense is chosen per pin: high or rising, or low or falling. A per-pin option lets an edge-mode pin fire on either transition.

Edge events are latched into a status register and acknowledged by writing ones. Level-mode status follows the synchronized pin. A pin raises the combined interrupt line when its status bit and its enable-mask bit are both 1. The enable mask can be loaded whole, or have bits set through a separate write-one-to-enable register.

Software drives the register port with one request per cycle. A read returns its data on `rdata_o` one cycle after the request.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is a general input, `pin_oe_o` and `irq_o` are 0, and every register reads 0.
- R2: Register byte offsets are: mode 0x00 (1 = interrupt input), direction 0x04 (1 = output), output data 0x08, input data 0x0C, status 0x10, status clear 0x14, mask 0x18, mask set 0x1C, sense 0x20 (1 = low/falling), edge select 0x24 (1 = edge), dual edge 0x4C. A read returns data on `rdata_o` in the cycle after the request. Offsets 0x14, 0x1C and unmapped offsets read 0. Writes to 0x0C and 0x10 have no effect.
- R3: `pin_o` equals the output-data register. A `pin_oe_o` bit is 1 exactly when that pin's direction bit is 1 and its mode bit is 0.
- R4: Input data shows the pin value after two register stages. A bit whose `pin_oe_o` is 1 reads 0.
- R5: A pin with mode 1 and edge select 0 shows status equal to the synchronized pin XOR its sense bit. A clear write does not change it.
- R6: A pin with mode 1, edge select 1 and dual edge 0 latches status on a rising synchronized edge when sense is 0, or on a falling edge when sense is 1. The bit holds until it is cleared.
- R7: With dual edge 1, an edge-mode pin latches on both rising and falling edges, whatever its sense bit.
- R8: Writing 1 to a bit of 0x14 clears that latched edge status, and writing 0 leaves it. An edge detected in the same cycle as the clear keeps the bit set.
- R9: A write to 0x18 loads the mask from the data. A write to 0x1C sets the mask bits written as 1 and leaves the others.
- R10: `irq_o` is 1 in the cycle after any bit of (status AND mask) is 1, and 0 otherwise.
- R11: A pin not in edge interrupt mode (mode 0 or edge select 0) holds no latched edge status. Its latch reads 0 once the pin returns to edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| pin_i | input | 32 | Pin input levels (asynchronous) |
| pin_o | output | 32 | Pin output levels |
| pin_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
Two functions can fall in the same cycle: a synchronized edge reaching the detector, and a status-clear write to that same bit. The bench provokes this by changing a pin and issuing the clear two cycles later. The edge then reaches the detector on the very edge that performs the clear, and the status read that follows must show the bit still set. A behavioural reference model tracks the synchronizer, latches, masks and read data every clock. It judges the directed coincidences and a long random mix of pin toggles, clears and configuration writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_DIR   = 8'h04;
  localparam logic [7:0] OFS_DOUT  = 8'h08;
  localparam logic [7:0] OFS_DIN   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_CLR   = 8'h14;
  localparam logic [7:0] OFS_MASK  = 8'h18;
  localparam logic [7:0] OFS_MSET  = 8'h1C;
  localparam logic [7:0] OFS_SENSE = 8'h20;
  localparam logic [7:0] OFS_EDGE  = 8'h24;
  localparam logic [7:0] OFS_DUAL  = 8'h4C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic int_en_i,
  input  logic edg_en_i,
  input  logic sense_i,
  input  logic dual_i,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q, lat_q, rise, fall, hit, edge_mode;

  assign rise      = s_i & ~prev_q;
  assign fall      = ~s_i & prev_q;
  assign hit       = dual_i ? (rise | fall) : (sense_i ? fall : rise);
  assign edge_mode = int_en_i & edg_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= s_i;
      // edge beats a same-cycle clear
      lat_q  <= edge_mode & (hit | (lat_q & ~clr_i));
    end
  end

  assign status_o = int_en_i & (edg_en_i ? lat_q : (s_i ^ sense_i));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && lat_q && !clr_i) |=> lat_q);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && lat_q && clr_i && !hit) |=> !lat_q);
  assert_edge_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && hit) |=> lat_q);
  assert_no_latch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode |=> !lat_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic          irq_o
);
  import gpio_pkg::*;

  logic [7:0]       offs;
  logic             wr, rd;
  logic [NPINS-1:0] mode_q, dir_q, dout_q, mask_q, sense_q, edge_q, dual_q;
  logic [NPINS-1:0] sync_s, status, clr, pend, din;
  logic [DW-1:0]    rmux;

  assign offs = 8'(addr_i);
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign clr  = (wr && offs == OFS_CLR) ? wdata_i[NPINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      edge_q  <= '0;
      dual_q  <= '0;
    end else if (wr) begin
      case (offs)
        OFS_MODE:  mode_q  <= wdata_i[NPINS-1:0];
        OFS_DIR:   dir_q   <= wdata_i[NPINS-1:0];
        OFS_DOUT:  dout_q  <= wdata_i[NPINS-1:0];
        OFS_MASK:  mask_q  <= wdata_i[NPINS-1:0];
        OFS_MSET:  mask_q  <= mask_q | wdata_i[NPINS-1:0];
        OFS_SENSE: sense_q <= wdata_i[NPINS-1:0];
        OFS_EDGE:  edge_q  <= wdata_i[NPINS-1:0];
        OFS_DUAL:  dual_q  <= wdata_i[NPINS-1:0];
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_s)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_pin_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .s_i     (sync_s[g]),
      .int_en_i(mode_q[g]),
      .edg_en_i(edge_q[g]),
      .sense_i (sense_q[g]),
      .dual_i  (dual_q[g]),
      .clr_i   (clr[g]),
      .status_o(status[g])
    );
  end

  assign pin_oe_o = dir_q & ~mode_q;
  assign pin_o    = dout_q;
  assign din      = sync_s & ~pin_oe_o;
  assign pend     = status & mask_q;

  always_comb begin
    rmux = '0;
    case (offs)
      OFS_MODE:  rmux = DW'(mode_q);
      OFS_DIR:   rmux = DW'(dir_q);
      OFS_DOUT:  rmux = DW'(dout_q);
      OFS_DIN:   rmux = DW'(din);
      OFS_STAT:  rmux = DW'(status);
      OFS_MASK:  rmux = DW'(mask_q);
      OFS_SENSE: rmux = DW'(sense_q);
      OFS_EDGE:  rmux = DW'(edge_q);
      OFS_DUAL:  rmux = DW'(dual_q);
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd) rdata_o <= rmux;
      irq_o <= |pend;
    end
  end

  assert_irq_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend) |=> irq_o);
  assert_irq_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend) |=> !irq_o);
  assert_mask_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && offs == OFS_MSET) |=>
      ((mask_q & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0])));
  assert_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && offs == OFS_MODE) |=> ((pin_oe_o & $past(wdata_i[NPINS-1:0])) == '0));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, pin_o, pin_oe;
  logic        irq;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R2", m_tag = "R2";

  logic [31:0] m_mode, m_dir, m_out, m_mask, m_sense, m_edge, m_dual;
  logic [31:0] m_lat, m_s1, m_s2, m_prev, m_rdata;
  logic        m_irq, m_rv;

  function automatic logic [31:0] m_status();
    return m_mode & ((m_edge & m_lat) | (~m_edge & (m_s2 ^ m_sense)));
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_mode;
      8'h04: return m_dir;
      8'h08: return m_out;
      8'h0C: return m_s2 & ~(m_dir & ~m_mode);
      8'h10: return m_status();
      8'h18: return m_mask;
      8'h20: return m_sense;
      8'h24: return m_edge;
      8'h4C: return m_dual;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_mode, m_dir, m_out, m_mask, m_sense, m_edge, m_dual} = '0;
      {m_lat, m_s1, m_s2, m_prev, m_rdata} = '0;
      m_irq = 0; m_rv = 0;
    end else begin
      logic [31:0] rise, fall, hit, clrv, st;
      st = m_status();
      m_rv = req && !we;
      if (m_rv) begin m_rdata = m_read({1'b0, addr}); m_tag = cur_tag; end
      m_irq = |(st & m_mask);
      rise = m_s2 & ~m_prev;
      fall = ~m_s2 & m_prev;
      hit  = (m_dual & (rise | fall)) | (~m_dual & ((~m_sense & rise) | (m_sense & fall)));
      clrv = (req && we && addr == 7'h14) ? wdata : 32'h0;
      m_lat = m_mode & m_edge & (hit | (m_lat & ~clrv));
      if (req && we) begin
        case (addr)
          7'h00: m_mode  = wdata;
          7'h04: m_dir   = wdata;
          7'h08: m_out   = wdata;
          7'h18: m_mask  = wdata;
          7'h1C: m_mask  = m_mask | wdata;
          7'h20: m_sense = wdata;
          7'h24: m_edge  = wdata;
          7'h4C: m_dual  = wdata;
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 pin_o", pin_o, m_out);
      chk("R3 pin_oe_o", pin_oe, m_dir & ~m_mode);
      chk("R10 irq_o", {31'b0, irq}, {31'b0, m_irq});
      if (m_rv) chk(m_tag, rdata, m_rdata);
    end else begin
      chk("R1 reset outputs", {pin_oe[30:0], irq}, 32'h0);
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); req = 0; we = 0; end
  endtask
  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask
  task automatic rd(logic [6:0] a, string tag);
    @(negedge clk); req = 1; we = 0; addr = a; cur_tag = tag;
    @(negedge clk); req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] alist [12] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14,
                               7'h18, 7'h1C, 7'h20, 7'h24, 7'h4C, 7'h30};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents
    foreach (alist[i]) rd(alist[i], "R1 reset read");
    // R2 / R3: general outputs
    wr(7'h08, 32'hA5A5_0F0F);
    wr(7'h04, 32'h0000_FFFF);
    rd(7'h08, "R2 dout"); rd(7'h04, "R2 dir");
    wr(7'h0C, 32'hFFFF_FFFF); wr(7'h10, 32'hFFFF_FFFF);
    rd(7'h0C, "R2 din write ignored"); rd(7'h30, "R2 unmapped");
    wr(7'h00, 32'h0000_0001);
    rd(7'h00, "R3 mode");
    // R4: inputs, driven bits hidden
    pins = 32'h1234_ABCD; idle(3); rd(7'h0C, "R4 din");
    pins = 32'hFEDC_5678; idle(1); rd(7'h0C, "R4 din early"); idle(2);
    rd(7'h0C, "R4 din settled");
    // R5: level sense
    wr(7'h04, 32'h0); wr(7'h00, 32'hF000_0000); wr(7'h20, 32'h3000_0000);
    pins = 32'h5000_0000; idle(3); rd(7'h10, "R5 level status");
    wr(7'h14, 32'hF000_0000); rd(7'h10, "R5 clear ignored");
    // R9 / R10: mask
    wr(7'h18, 32'h1000_0000); rd(7'h18, "R9 mask load");
    wr(7'h1C, 32'h2000_0000); rd(7'h18, "R9 mask set");
    pins = 32'h0; idle(4);
    wr(7'h18, 32'h0); idle(2);
    // R6 / R7: edges
    wr(7'h00, 32'h00FF_0000); wr(7'h24, 32'h00FF_0000);
    wr(7'h20, 32'h00F0_0000); wr(7'h4C, 32'h000C_0000);
    wr(7'h14, 32'hFFFF_FFFF);
    pins = 32'h00FF_0000; idle(4); rd(7'h10, "R6 R7 rising");
    pins = 32'h0; idle(4); rd(7'h10, "R6 R7 falling held");
    wr(7'h14, 32'h0000_0000); rd(7'h10, "R8 zero write");
    wr(7'h14, 32'h000F_0000); rd(7'h10, "R8 clear");
    wr(7'h18, 32'h00FF_0000); idle(2);
    // R8: edge coincides with clear
    wr(7'h14, 32'h00FF_0000); idle(1);
    @(negedge clk); pins = 32'h0001_0000;
    @(negedge clk); @(negedge clk);
    req = 1; we = 1; addr = 7'h14; wdata = 32'h0001_0000;
    @(negedge clk); req = 0; we = 0;
    rd(7'h10, "R8 edge beats clear");
    // R11: leaving edge mode drops latch
    wr(7'h24, 32'h0); wr(7'h24, 32'h00FF_0000); rd(7'h10, "R11 latch dropped");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int c = $urandom_range(0, 9);
      if (c < 3) pins = $urandom();
      else if (c < 6) rd(alist[$urandom_range(0, 11)], "R2 R5 R6 R7 R8 R11 random read");
      else if (c < 9) wr(alist[$urandom_range(0, 11)], $urandom() & $urandom());
      else idle(1);
    end
    idle(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule